// File: doc/BRIEF.md
# Overheat Threshold Monitor with Hysteresis

This block watches a stream of temperature sample codes and flags an overheat condition. Every sample that arrives with its valid strobe is compared against two watermarks built around a programmed threshold: a high watermark at threshold plus an offset, and a low watermark at threshold minus the same offset. The offset comes from a 2-bit hysteresis code. Each code selects a precomputed code-unit distance whose temperature span doubles from one code to the next, about 1.9, 3.8, 7.6 and 15.2 degrees. Crossing the high watermark while the detector is armed and the local enable is on latches a sticky cause bit and disarms the detector. The detector re-arms only when a valid sample falls below the low watermark. A continuous overheat therefore produces exactly one event. Reading the cause clears it without re-arming the detector.

The interrupt line is the cause bit gated by two mask levels: a mask for this source and a mask at the interrupt-server level. Sample acquisition and conversion to degrees happen elsewhere. The block works in raw code units. A parameter selects whether a hotter die gives a higher or a lower code, and the comparison direction follows that choice. Monitoring applies to whatever sensor channel feeds the sample input, so the event source follows the currently selected channel.

Top module: `overheat_watch`

## Requirements
- R1: After reset, cause_rdata and irq_o are 0, the detector is armed, the threshold is all ones, the hysteresis code is 0, and the enable and both masks are 0.
- R2: With default direction (higher code is hotter), a valid sample whose code is at or above threshold + offset[h] (saturating at the largest code) sets cause_rdata at the clock edge that takes the sample, provided the detector is armed and the enable is 1. A code one below that watermark does not set it.
- R3: A sample presented with smp_vld at 0 has no effect on cause or on the armed state.
- R4: Once an event has fired, further hot samples raise no new event, even after the cause has been read and cleared, until the detector is re-armed.
- R5: Only a valid sample strictly below threshold - offset[h] (saturating at 0) re-arms the detector. A sample at the low watermark or between the two watermarks does not re-arm it.
- R6: Hysteresis code h = 0, 1, 2, 3 selects offsets of 2, 4, 8 and 16 codes by default (parameters HYST_OFS0..HYST_OFS3).
- R7: While the enable is 0, a hot sample neither sets the cause nor disarms the detector. A hot sample after the enable is set still raises an event.
- R8: cause_rdata shows the sticky cause. Pulsing cause_rd clears it at that clock edge. If a new event occurs in the same cycle as the read, the cause stays set.
- R9: irq_o is 1 exactly when the cause is set and both the source mask and the server mask are 1.
- R10: Each configuration write port updates its field at the clock edge on which its write strobe is high, and the field keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_vld | input | 1 | Sample valid strobe |
| smp_code | input | CODE_W | Temperature sample code |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | CODE_W | Threshold value in code units |
| hys_we | input | 1 | Hysteresis code write strobe |
| hys_wdata | input | 2 | Hysteresis code |
| ien_we | input | 1 | Local event enable write strobe |
| ien_wdata | input | 1 | Local event enable value |
| smask_we | input | 1 | Source mask write strobe |
| smask_wdata | input | 1 | Source mask value (1 = pass) |
| vmask_we | input | 1 | Server mask write strobe |
| vmask_wdata | input | 1 | Server mask value (1 = pass) |
| cause_rd | input | 1 | Cause read strobe (read clears) |
| cause_rdata | output | 1 | Sticky overheat cause |
| irq_o | output | 1 | Masked interrupt line |

## Verification
Every result in this block appears in the cycle of its stimulus. A sample, a configuration write or a cause read registers at the rising edge on which it is presented. The cause, the armed state and every field change at that edge. irq_o follows combinationally from the registered cause and masks. The bench therefore drives each stimulus at a falling edge and samples the outputs one nanosecond after the next rising edge. It then drops all strobes, so each check sees the effect of exactly one edge. Facts that have no pin of their own are inferred from later port behaviour: the armed state from whether a following hot sample raises the cause, and the offsets from the exact code at which the cause appears.

// File: rtl/ohw_pkg.sv
package ohw_pkg;
  localparam int HYST_W = 2;
  localparam int N_HYST = 1 << HYST_W;

  typedef enum logic {
    ST_ARMED   = 1'b0,
    ST_TRIPPED = 1'b1
  } ohw_state_e;
endpackage

// File: rtl/ohw_cfg_regs.sv
module ohw_cfg_regs
  import ohw_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_we,
  input  logic [CODE_W-1:0] thr_wdata,
  input  logic              hys_we,
  input  logic [HYST_W-1:0] hys_wdata,
  input  logic              ien_we,
  input  logic              ien_wdata,
  input  logic              smask_we,
  input  logic              smask_wdata,
  input  logic              vmask_we,
  input  logic              vmask_wdata,
  output logic [CODE_W-1:0] thr_q,
  output logic [HYST_W-1:0] hys_q,
  output logic              ien_q,
  output logic              smask_q,
  output logic              vmask_q
);
  logic [CODE_W-1:0] thr_d;
  logic [HYST_W-1:0] hys_d;
  logic              ien_d;
  logic              smask_d;
  logic              vmask_d;

  always_comb begin
    thr_d   = thr_q;
    hys_d   = hys_q;
    ien_d   = ien_q;
    smask_d = smask_q;
    vmask_d = vmask_q;
    if (thr_we)   thr_d   = thr_wdata;
    if (hys_we)   hys_d   = hys_wdata;
    if (ien_we)   ien_d   = ien_wdata;
    if (smask_we) smask_d = smask_wdata;
    if (vmask_we) vmask_d = vmask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '1;
      hys_q <= '0;
    end else begin
      if (thr_we) thr_q <= thr_d;
      if (hys_we) hys_q <= hys_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= 1'b0;
      smask_q <= 1'b0;
      vmask_q <= 1'b0;
    end else begin
      if (ien_we)   ien_q   <= ien_d;
      if (smask_we) smask_q <= smask_d;
      if (vmask_we) vmask_q <= vmask_d;
    end
  end
endmodule

// File: rtl/ohw_window.sv
module ohw_window
  import ohw_pkg::*;
#(
  parameter int                         CODE_W      = 10,
  parameter bit                         HOT_IS_HIGH = 1'b1,
  parameter logic [N_HYST*CODE_W-1:0]   OFS_PACK    = '0
) (
  input  logic [CODE_W-1:0] thr,
  input  logic [HYST_W-1:0] hys,
  input  logic [CODE_W-1:0] code,
  output logic              hot,
  output logic              cool
);
  localparam logic [CODE_W:0] CODE_MAX = {1'b0, {CODE_W{1'b1}}};

  logic [CODE_W-1:0] ofs_tbl [N_HYST];
  logic [CODE_W-1:0] ofs;
  logic [CODE_W:0]   sum_ext;
  logic [CODE_W-1:0] wm_hi;
  logic [CODE_W-1:0] wm_lo;

  for (genvar g = 0; g < N_HYST; g++) begin : g_ofs
    assign ofs_tbl[g] = OFS_PACK[g*CODE_W +: CODE_W];
  end

  always_comb begin
    ofs     = ofs_tbl[hys];
    sum_ext = {1'b0, thr} + {1'b0, ofs};
    wm_hi   = (sum_ext > CODE_MAX) ? CODE_MAX[CODE_W-1:0] : sum_ext[CODE_W-1:0];
    wm_lo   = (thr < ofs) ? '0 : (thr - ofs);
  end

  if (HOT_IS_HIGH) begin : g_up
    assign hot  = (code >= wm_hi);
    assign cool = (code <  wm_lo);
  end else begin : g_down
    assign hot  = (code <= wm_lo);
    assign cool = (code >  wm_hi);
  end
endmodule

// File: rtl/ohw_detect.sv
module ohw_detect
  import ohw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic hot,
  input  logic cool,
  input  logic ien,
  input  logic cause_rd,
  output logic armed,
  output logic cause_q
);
  ohw_state_e st_q, st_d;
  logic       evt;
  logic       cause_d;
  logic       cause_en;
  logic       st_en;

  always_comb begin
    evt      = smp_vld && hot && ien && (st_q == ST_ARMED);
    st_d     = st_q;
    case (st_q)
      ST_ARMED:   if (evt) st_d = ST_TRIPPED;
      ST_TRIPPED: if (smp_vld && cool) st_d = ST_ARMED;
      default:    st_d = ST_ARMED;
    endcase
    st_en    = (st_d != st_q);
    cause_d  = evt || (cause_q && !cause_rd);
    cause_en = evt || cause_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_ARMED;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign armed = (st_q == ST_ARMED);
endmodule

// File: rtl/overheat_watch.sv
module overheat_watch
  import ohw_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter bit HOT_IS_HIGH = 1'b1,
  parameter int HYST_OFS0   = 2,
  parameter int HYST_OFS1   = 4,
  parameter int HYST_OFS2   = 8,
  parameter int HYST_OFS3   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              thr_we,
  input  logic [CODE_W-1:0] thr_wdata,
  input  logic              hys_we,
  input  logic [1:0]        hys_wdata,
  input  logic              ien_we,
  input  logic              ien_wdata,
  input  logic              smask_we,
  input  logic              smask_wdata,
  input  logic              vmask_we,
  input  logic              vmask_wdata,
  input  logic              cause_rd,
  output logic              cause_rdata,
  output logic              irq_o
);
  localparam logic [N_HYST*CODE_W-1:0] OFS_PACK = {
    CODE_W'(HYST_OFS3), CODE_W'(HYST_OFS2),
    CODE_W'(HYST_OFS1), CODE_W'(HYST_OFS0)
  };

  logic [CODE_W-1:0] thr_q;
  logic [HYST_W-1:0] hys_q;
  logic              ien_q;
  logic              smask_q;
  logic              vmask_q;
  logic              hot;
  logic              cool;
  logic              armed;
  logic              cause_q;

  ohw_cfg_regs #(.CODE_W(CODE_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .thr_we     (thr_we),
    .thr_wdata  (thr_wdata),
    .hys_we     (hys_we),
    .hys_wdata  (hys_wdata),
    .ien_we     (ien_we),
    .ien_wdata  (ien_wdata),
    .smask_we   (smask_we),
    .smask_wdata(smask_wdata),
    .vmask_we   (vmask_we),
    .vmask_wdata(vmask_wdata),
    .thr_q      (thr_q),
    .hys_q      (hys_q),
    .ien_q      (ien_q),
    .smask_q    (smask_q),
    .vmask_q    (vmask_q)
  );

  ohw_window #(
    .CODE_W     (CODE_W),
    .HOT_IS_HIGH(HOT_IS_HIGH),
    .OFS_PACK   (OFS_PACK)
  ) u_win (
    .thr (thr_q),
    .hys (hys_q),
    .code(smp_code),
    .hot (hot),
    .cool(cool)
  );

  ohw_detect u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .hot     (hot),
    .cool    (cool),
    .ien     (ien_q),
    .cause_rd(cause_rd),
    .armed   (armed),
    .cause_q (cause_q)
  );

  assign cause_rdata = cause_q;
  assign irq_o       = cause_q && smask_q && vmask_q;
endmodule

// File: rtl/ohw_checker.sv
module ohw_checker (
  input logic clk,
  input logic rst_n,
  input logic smp_vld,
  input logic cause_rd,
  input logic cause_rdata,
  input logic irq_o,
  input logic ien,
  input logic armed
);
  AST_NO_SET_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !cause_rdata) |=> !cause_rdata); // R3

  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && cause_rd) |=> !cause_rdata); // R4

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_rdata) |-> $past(ien)); // R7

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rdata && !cause_rd) |=> cause_rdata); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rd && !smp_vld) |=> !cause_rdata); // R8

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cause_rdata); // R9

  AST_TRIP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_rdata) |-> !armed); // R4
endmodule

bind overheat_watch ohw_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_vld    (smp_vld),
  .cause_rd   (cause_rd),
  .cause_rdata(cause_rdata),
  .irq_o      (irq_o),
  .ien        (ien_q),
  .armed      (armed)
);

// File: tb/overheat_watch_tb.sv
module overheat_watch_tb;
  localparam int CODE_W = 10;
  localparam int NVEC   = 11;
  // {vld, code[9:0], rd, exp_cause}; threshold 500, h=1 (offset 4), all gates open
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 10'd503, 1'b0, 1'b0},  // R2 one below high watermark
    {1'b1, 10'd504, 1'b0, 1'b1},  // R2 at high watermark
    {1'b1, 10'd510, 1'b1, 1'b0},  // R4 read clears, no retrigger
    {1'b1, 10'd520, 1'b0, 1'b0},  // R4 still hot, no event
    {1'b1, 10'd496, 1'b0, 1'b0},  // R5 at low watermark: no rearm
    {1'b1, 10'd504, 1'b0, 1'b0},  // R5 proves still disarmed
    {1'b1, 10'd495, 1'b0, 1'b0},  // R5 below low: rearm
    {1'b0, 10'd600, 1'b0, 1'b0},  // R3 invalid hot sample
    {1'b1, 10'd504, 1'b0, 1'b1},  // R2 event after rearm
    {1'b0, 10'd0,   1'b0, 1'b1},  // R8 sticky
    {1'b0, 10'd0,   1'b1, 1'b0}   // R8 read clears
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              smp_vld, thr_we, hys_we, ien_we, smask_we, vmask_we, cause_rd;
  logic [CODE_W-1:0] smp_code, thr_wdata;
  logic [1:0]        hys_wdata;
  logic              ien_wdata, smask_wdata, vmask_wdata;
  logic              cause_rdata, irq_o;
  int                n_chk = 0;
  int                n_err = 0;
  bit                done  = 1'b0;

  always #2 clk = ~clk;

  overheat_watch u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .hys_we(hys_we), .hys_wdata(hys_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .smask_we(smask_we),
    .smask_wdata(smask_wdata), .vmask_we(vmask_we), .vmask_wdata(vmask_wdata),
    .cause_rd(cause_rd), .cause_rdata(cause_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    smp_vld = 0; smp_code = '0; thr_we = 0; thr_wdata = '0; hys_we = 0; hys_wdata = '0;
    ien_we = 0; ien_wdata = 0; smask_we = 0; smask_wdata = 0; vmask_we = 0;
    vmask_wdata = 0; cause_rd = 0;
  endtask

  task automatic edge_done();
    @(posedge clk); #1;
  endtask

  task automatic sample(input logic v, input int code, input logic rd);
    @(negedge clk);
    smp_vld = v; smp_code = CODE_W'(code); cause_rd = rd;
    edge_done();
    smp_vld = 0; cause_rd = 0;
  endtask

  task automatic set_thr(input int t);
    @(negedge clk); thr_we = 1; thr_wdata = CODE_W'(t);
    edge_done(); thr_we = 0;
  endtask

  task automatic set_hys(input int h);
    @(negedge clk); hys_we = 1; hys_wdata = 2'(h);
    edge_done(); hys_we = 0;
  endtask

  task automatic set_ien(input logic b);
    @(negedge clk); ien_we = 1; ien_wdata = b;
    edge_done(); ien_we = 0;
  endtask

  task automatic set_masks(input logic s, input logic v);
    @(negedge clk); smask_we = 1; smask_wdata = s; vmask_we = 1; vmask_wdata = v;
    edge_done(); smask_we = 0; vmask_we = 0;
  endtask

  // cool sample re-arms, read clears any cause
  task automatic rearm_clear();
    sample(1'b1, 0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 cause after reset", cause_rdata, 0);
    check("R1 irq after reset", irq_o, 0);
    // R1: enable is 0 at reset, so the largest code must not trip
    sample(1'b1, 1023, 1'b0);
    check("R1 enable off at reset", cause_rdata, 0);

    set_thr(500); set_hys(1); set_ien(1); set_masks(1, 1);
    for (int i = 0; i < NVEC; i++) begin
      sample(VEC[i][12], int'(VEC[i][11:2]), VEC[i][1]);
      check($sformatf("R2-table row %0d cause", i), cause_rdata, VEC[i][0]);
      check($sformatf("R9 table row %0d irq", i), irq_o, VEC[i][0]);
    end

    // R6: offsets 2,4,8,16 around threshold 300
    set_thr(300);
    for (int h = 0; h < 4; h++) begin
      int ofs;
      ofs = 2 << h;
      set_hys(h);
      rearm_clear();
      sample(1'b1, 300 + ofs - 1, 1'b0);
      check($sformatf("R6 h=%0d below high", h), cause_rdata, 0);
      sample(1'b1, 300 + ofs, 1'b0);
      check($sformatf("R6 h=%0d at high", h), cause_rdata, 1);
      // R6 low watermark: at 300-ofs no rearm, one below rearms
      sample(1'b1, 300 - ofs, 1'b1);
      sample(1'b1, 300 + ofs, 1'b0);
      check($sformatf("R6 h=%0d at low no rearm", h), cause_rdata, 0);
      sample(1'b1, 300 - ofs - 1, 1'b0);
      sample(1'b1, 300 + ofs, 1'b0);
      check($sformatf("R6 h=%0d below low rearms", h), cause_rdata, 1);
    end

    // R2 saturation: threshold 1020, h=3 -> high watermark clips to 1023
    set_thr(1020); set_hys(3); rearm_clear();
    sample(1'b1, 1022, 1'b0);
    check("R2 saturated below", cause_rdata, 0);
    sample(1'b1, 1023, 1'b0);
    check("R2 saturated high", cause_rdata, 1);

    // R7: enable off, hot sample neither sets nor disarms
    set_thr(500); set_hys(1); rearm_clear();
    set_ien(0);
    sample(1'b1, 600, 1'b0);
    check("R7 disabled no cause", cause_rdata, 0);
    set_ien(1);
    sample(1'b1, 600, 1'b0);
    check("R7 still armed after disabled hot", cause_rdata, 1);

    // R9: mask combinations with cause set
    set_masks(0, 1);
    check("R9 source mask closed", irq_o, 0);
    set_masks(1, 0);
    check("R9 server mask closed", irq_o, 0);
    set_masks(1, 1);
    check("R9 both open", irq_o, 1);

    // R8: event in the same cycle as a read keeps the cause set
    rearm_clear();
    check("R8 cleared before collision", cause_rdata, 0);
    sample(1'b1, 600, 1'b1);
    check("R8 set wins over read", cause_rdata, 1);

    // R10: a held field is not disturbed by other strobes
    sample(1'b0, 0, 1'b1);
    set_hys(0);
    rearm_clear();
    sample(1'b1, 501, 1'b0);
    check("R10 threshold kept at 500", cause_rdata, 0);
    sample(1'b1, 502, 1'b0);
    check("R10 threshold with new hysteresis", cause_rdata, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule